// File: doc/BRIEF.md
# Flash Wrapper Transaction Controller

This block is a synthesizable behavioural stand-in for the wrapper around a flash macro. A requester presents read, program or page-erase commands. Each command is answered twice. An acknowledge pulse in the cycle the command is taken. A done pulse later, when the operation has finished. Reads finish quickly, and two of them may be in flight together. Program and erase are modelled with parameterised cycle counts, and during those counts no new command is taken. The storage is a small register array that comes out of reset erased (all ones).

An erase that is running can be cut short with a suspend request. The suspend is acknowledged in the cycle it is taken, and the erase then reports done early and leaves its page untouched. Each program command carries a type code. A type that is not in the supported-type mask does not touch the storage. Instead it sets an error bit for the bank that was addressed. The error bits drive a level interrupt and are cleared by a write-one-to-clear port.

Top module: `flash_txn_ctrl`

## Requirements
- R1: After reset, `ack`, `done`, `susp_ack`, `err_irq` and `err_status` are low, and every stored word reads back as all ones.
- R2: An idle block acknowledges a read in the same cycle it is requested. `done` pulses exactly two cycles after that acknowledge, with `rd_data` holding the addressed word in that cycle.
- R3: A read requested in the cycle after a read acknowledge is itself acknowledged before the first read's done, so two reads are outstanding. The two dones follow in consecutive cycles, in request order.
- R4: A program of a supported type pulses `done` exactly `PROG_LAT` cycles after its acknowledge, and the stored word becomes the bitwise AND of its old value and `req_wdata`.
- R5: An erase pulses `done` exactly `ERASE_LAT` cycles after its acknowledge. Every word whose address bits above the low `PAGE_W` bits match the request becomes all ones, and all other words are unchanged.
- R6: From the cycle after a program or erase acknowledge up to and including its done cycle, no request is acknowledged. A request held across that window is acknowledged in the cycle after done.
- R7: A suspend request during an erase whose done is still r ≥ 1 cycles away is acknowledged in that same cycle (a one-cycle pulse). The erase's done then comes min(r, `SUSP_LAT`) cycles later, and the page keeps its contents.
- R8: A suspend request while no erase is running (idle, or during a program) gives no `susp_ack` and changes neither the program's timing nor its result.
- R9: A program whose type index selects a zero bit of `PROG_MASK` (default mask 4'b0011: types 0 and 1 supported) still gets ack and done at program timing. It leaves the storage unchanged and sets `err_status` bit b, where b is the address's top `$clog2(NUM_BANKS)` bits, in the cycle after done.
- R10: `err_irq` is high exactly while any `err_status` bit is set.
- R11: Driving `err_clr_we` with bit b of `err_clr_data` set clears `err_status[b]` in the next cycle. If a new error for bank b is raised in the same cycle, the set wins and the bit stays high.
- R12: When several requests are asserted together, read takes priority over program, and program over erase. Only the winner is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Read request, held until acknowledged |
| req_prog | input | 1 | Program request, held until acknowledged |
| req_erase | input | 1 | Page erase request, held until acknowledged |
| req_addr | input | ADDR_W | Word address of the request |
| req_ptype | input | PT_W | Program type index |
| req_wdata | input | DATA_W | Program data |
| susp_req | input | 1 | Erase suspend request |
| ack | output | 1 | Request accepted this cycle |
| done | output | 1 | Operation completed this cycle |
| rd_data | output | DATA_W | Read data, valid when a read's done pulses |
| susp_ack | output | 1 | Suspend accepted this cycle |
| err_clr_we | input | 1 | Write strobe of the clear port |
| err_clr_data | input | NUM_BANKS | Ones clear the matching status bits |
| err_status | output | NUM_BANKS | Per-bank error status |
| err_irq | output | 1 | Level error interrupt |

## Verification
Two functions can land in the same cycle: an unsupported program reaching done, which raises a bank's error bit, and a write-one-to-clear aimed at that same bit. The bench waits for the done pulse of a deliberately unsupported program and drives the clear in that very cycle. It then expects the bit and the interrupt to stay high, and expects a later clear on its own to drop both. Random command mixes around this collision check that error bits, interrupt level and stored data keep matching the bench's own model.

// File: rtl/fw_pkg.sv
// Package: shared types of the flash wrapper transaction controller.
// Assumes nothing beyond IEEE 1800-2017.
package fw_pkg;
    // Kind of long operation held by the sequencer
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } long_op_e;
endpackage

// File: rtl/fw_seq.sv
// Module: long-operation sequencer. Holds one program or erase, counts its
// latency down, handles an erase suspend and signals commit or fault at done.
// Assumes: start is only raised while not busy; PROG_LAT, ERASE_LAT >= 2;
// SUSP_LAT >= 1 and SUSP_LAT <= ERASE_LAT.
module fw_seq
    import fw_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PT_W      = 2,
    parameter logic [(1<<PT_W)-1:0] PROG_MASK = 4'b0011,
    parameter int PROG_LAT  = 6,
    parameter int ERASE_LAT = 20,
    parameter int SUSP_LAT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic [PT_W-1:0]   start_type,
    input  logic              susp_req,
    output logic              busy,
    output logic              is_erase,
    output logic              long_done,
    output logic              susp_ack,
    output logic              wr_prog,
    output logic              wr_erase,
    output logic              type_fault,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    localparam int MAX_LAT = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_LAT - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_LAT - 1);
    localparam logic [CNT_W-1:0] SUSP_LOAD  = CNT_W'(SUSP_LAT - 1);

    long_op_e         op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             susp_q;
    logic             bad_q;

    // Decode state into the completion and suspend strobes
    always_comb begin
        busy       = (op_q != OP_NONE);
        is_erase   = (op_q == OP_ERASE);
        long_done  = busy && (cnt_q == '0);
        susp_ack   = susp_req && is_erase && !susp_q && (cnt_q != '0);
        wr_prog    = long_done && (op_q == OP_PROG) && !bad_q;
        type_fault = long_done && (op_q == OP_PROG) && bad_q;
        wr_erase   = long_done && is_erase && !susp_q;
        cnt_dec    = cnt_q - 1'b1;
    end

    // Capture a new operation, count it down, shorten it on suspend
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            cnt_q   <= '0;
            susp_q  <= 1'b0;
            bad_q   <= 1'b0;
            op_addr <= '0;
            op_data <= '0;
        end else if (start_prog || start_erase) begin
            op_q    <= start_prog ? OP_PROG : OP_ERASE;
            cnt_q   <= start_prog ? PROG_LOAD : ERASE_LOAD;
            susp_q  <= 1'b0;
            bad_q   <= start_prog && !PROG_MASK[start_type];
            op_addr <= start_addr;
            op_data <= start_data;
        end else if (long_done) begin
            op_q   <= OP_NONE;
            susp_q <= 1'b0;
        end else if (busy) begin
            if (susp_ack) begin
                susp_q <= 1'b1;
                cnt_q  <= (cnt_dec < SUSP_LOAD) ? cnt_dec : SUSP_LOAD;
            end else begin
                cnt_q <= cnt_dec;
            end
        end
    end
endmodule

// File: rtl/fw_array.sv
// Module: register-based storage. Resets to all ones; program ANDs data into
// one word; erase sets a whole page to ones. Combinational read port.
// Assumes wr_prog and wr_erase are never high together.
module fw_array #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_prog,
    input  logic              wr_erase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int PG_W  = ADDR_W - PAGE_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Update every word: reset, program AND, or page erase
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (!rst_n) begin
                mem[w] <= '1;
            end else if (wr_prog && (wr_addr == ADDR_W'(w))) begin
                mem[w] <= mem[w] & wr_data;
            end else if (wr_erase && (PG_W'(w >> PAGE_W) == wr_addr[ADDR_W-1:PAGE_W])) begin
                mem[w] <= '1;
            end
        end
    end

    // Read the addressed word
    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/fw_rdpipe.sv
// Module: two-stage read pipeline. A read taken in cycle c looks up storage
// in cycle c+1 and presents done and data in cycle c+2. Accepts one read per
// cycle, so at most two are outstanding.
module fw_rdpipe #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] take_addr,
    input  logic [DATA_W-1:0] arr_word,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    logic s1_v;
    logic s2_v;

    // Advance the address stage and the data stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            arr_addr <= '0;
            s2_v     <= 1'b0;
            rd_data  <= '0;
        end else begin
            s1_v     <= take;
            arr_addr <= take ? take_addr : arr_addr;
            s2_v     <= s1_v;
            rd_data  <= s1_v ? arr_word : rd_data;
        end
    end

    assign rd_done = s2_v;
endmodule

// File: rtl/fw_errstat.sv
// Module: per-bank error status with write-one-to-clear and a level IRQ.
// A set in the same cycle as a clear of that bit wins.
module fw_errstat #(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fault,
    input  logic [ADDR_W-1:0]    fault_addr,
    input  logic                 clr_we,
    input  logic [NUM_BANKS-1:0] clr_data,
    output logic [NUM_BANKS-1:0] status,
    output logic                 irq
);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_BANKS-1:0] set_vec;
    logic [NUM_BANKS-1:0] clr_vec;

    // Decode the faulting bank from the top address bits
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (NUM_BANKS > 1) begin : g_multi
            assign set_vec[b] = fault && (fault_addr[ADDR_W-1 -: BANK_W] == BANK_W'(b));
        end else begin : g_single
            assign set_vec[b] = fault;
        end
    end

    assign clr_vec = clr_we ? clr_data : '0;

    // Hold status: clear by write-one, set by fault (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    assign irq = |status;
endmodule

// File: rtl/flash_txn_ctrl.sv
// Module: flash wrapper transaction controller (top). Arbitrates read >
// program > erase, gives a combinational ack, and returns done from either
// the read pipeline or the long-operation sequencer.
// Assumes requests are held until ack; parameter limits as in fw_seq.
module flash_txn_ctrl
    import fw_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PAGE_W    = 2,
    parameter int NUM_BANKS = 2,
    parameter int PT_W      = 2,
    parameter logic [(1<<PT_W)-1:0] PROG_MASK = 4'b0011,
    parameter int PROG_LAT  = 6,
    parameter int ERASE_LAT = 20,
    parameter int SUSP_LAT  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_rd,
    input  logic                 req_prog,
    input  logic                 req_erase,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [PT_W-1:0]      req_ptype,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 susp_req,
    output logic                 ack,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 susp_ack,
    input  logic                 err_clr_we,
    input  logic [NUM_BANKS-1:0] err_clr_data,
    output logic [NUM_BANKS-1:0] err_status,
    output logic                 err_irq
);
    logic              seq_busy, seq_is_erase, long_done;
    logic              wr_prog, wr_erase, type_fault;
    logic [ADDR_W-1:0] op_addr, arr_addr;
    logic [DATA_W-1:0] op_data, arr_word;
    logic              take_rd, take_prog, take_erase, rd_done;

    // Arbitrate requests while no long operation is held
    always_comb begin
        take_rd    = req_rd && !seq_busy;
        take_prog  = req_prog && !req_rd && !seq_busy;
        take_erase = req_erase && !req_rd && !req_prog && !seq_busy;
        ack        = take_rd || take_prog || take_erase;
        done       = rd_done || long_done;
    end

    fw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PT_W(PT_W), .PROG_MASK(PROG_MASK),
        .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT), .SUSP_LAT(SUSP_LAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_prog(take_prog), .start_erase(take_erase),
        .start_addr(req_addr), .start_data(req_wdata), .start_type(req_ptype),
        .susp_req(susp_req),
        .busy(seq_busy), .is_erase(seq_is_erase), .long_done(long_done),
        .susp_ack(susp_ack), .wr_prog(wr_prog), .wr_erase(wr_erase),
        .type_fault(type_fault), .op_addr(op_addr), .op_data(op_data)
    );

    fw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_prog(wr_prog), .wr_erase(wr_erase),
        .wr_addr(op_addr), .wr_data(op_data),
        .rd_addr(arr_addr), .rd_word(arr_word)
    );

    fw_rdpipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdpipe (
        .clk(clk), .rst_n(rst_n),
        .take(take_rd), .take_addr(req_addr),
        .arr_word(arr_word), .arr_addr(arr_addr),
        .rd_done(rd_done), .rd_data(rd_data)
    );

    fw_errstat #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_err (
        .clk(clk), .rst_n(rst_n),
        .fault(type_fault), .fault_addr(op_addr),
        .clr_we(err_clr_we), .clr_data(err_clr_data),
        .status(err_status), .irq(err_irq)
    );
endmodule

// File: rtl/fw_checker.sv
// Module: protocol checker for flash_txn_ctrl, attached with bind.
module fw_checker #(
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_rd,
    input logic                 ack,
    input logic                 done,
    input logic                 susp_ack,
    input logic                 rd_done,
    input logic                 long_done,
    input logic                 seq_busy,
    input logic                 seq_is_erase,
    input logic                 err_clr_we,
    input logic [NUM_BANKS-1:0] err_clr_data,
    input logic [NUM_BANKS-1:0] err_status,
    input logic                 err_irq
);
    assert_rd_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && ack) |-> ##2 (done && rd_done));

    assert_no_done_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && long_done));

    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req_rd) |=> !ack);

    assert_susp_only_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ack |-> (seq_busy && seq_is_erase));

    assert_susp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ack |=> !susp_ack);

    assert_irq_from_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(long_done));

    assert_w1c_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_we && !long_done) |=> ((err_status & $past(err_clr_data)) == '0));
endmodule

bind flash_txn_ctrl fw_checker #(.NUM_BANKS(NUM_BANKS)) u_fw_checker (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .ack(ack), .done(done),
    .susp_ack(susp_ack), .rd_done(rd_done), .long_done(long_done),
    .seq_busy(seq_busy), .seq_is_erase(seq_is_erase),
    .err_clr_we(err_clr_we), .err_clr_data(err_clr_data),
    .err_status(err_status), .err_irq(err_irq)
);

// File: tb/flash_txn_ctrl_test.sv
`timescale 1ns/1ps
module flash_txn_ctrl_test;
    localparam int ADDR_W = 5, DATA_W = 16, PAGE_W = 2, NB = 2, PT_W = 2;
    localparam logic [3:0] MASK = 4'b0011;
    localparam int PROG_LAT = 6, ERASE_LAT = 20, SUSP_LAT = 3;
    localparam int WORDS = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_rd = 0, req_prog = 0, req_erase = 0, susp_req = 0, err_clr_we = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PT_W-1:0] req_ptype = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [NB-1:0] err_clr_data = '0;
    logic ack, done, susp_ack, err_irq;
    logic [DATA_W-1:0] rd_data;
    logic [NB-1:0] err_status;

    int nchk = 0, nerr = 0;
    logic [DATA_W-1:0] mem_m [WORDS];
    logic [NB-1:0] stat_m = '0;

    always #2 clk = ~clk;

    flash_txn_ctrl #(.PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT), .SUSP_LAT(SUSP_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_prog(req_prog),
        .req_erase(req_erase), .req_addr(req_addr), .req_ptype(req_ptype),
        .req_wdata(req_wdata), .susp_req(susp_req), .ack(ack), .done(done),
        .rd_data(rd_data), .susp_ack(susp_ack), .err_clr_we(err_clr_we),
        .err_clr_data(err_clr_data), .err_status(err_status), .err_irq(err_irq)
    );

    function automatic int bank_of(input int a);
        return a >> (ADDR_W - 1);
    endfunction
    function automatic bit same_page(input int a, input int b);
        return (a >> PAGE_W) == (b >> PAGE_W);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    // Drive a request at a negedge and hold it until acknowledged
    task automatic issue(input bit r, input bit p, input bit e, input int a,
                         input int t, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_rd = r; req_prog = p; req_erase = e;
        req_addr = ADDR_W'(a); req_ptype = PT_W'(t); req_wdata = d;
        #1;
        while (!ack) begin @(negedge clk); #1; end
        @(negedge clk);
        req_rd = 0; req_prog = 0; req_erase = 0;
    endtask

    // Count cycles from the ack cycle to the done cycle
    task automatic wait_done(output int n);
        n = 1; #1;
        while (!done && n < 400) begin @(negedge clk); #1; n++; end
    endtask

    task automatic model_erase(input int a);
        for (int w = 0; w < WORDS; w++) if (same_page(w, a)) mem_m[w] = '1;
    endtask

    // One operation with latency, data and status checks against the model
    task automatic run_op(input int kind, input int a, input int t, input logic [DATA_W-1:0] d);
        int n;
        issue(kind == 0, kind == 1, kind == 2, a, t, d);
        wait_done(n);
        if (kind == 0) begin
            chk(n == 2, "R2 read latency", n, 2);
            chk(rd_data == mem_m[a], "R2 read data", rd_data, mem_m[a]);
        end else if (kind == 1) begin
            chk(n == PROG_LAT, "R4 program latency", n, PROG_LAT);
            if (MASK[t]) mem_m[a] = mem_m[a] & d;
            else stat_m[bank_of(a)] = 1'b1;
        end else begin
            chk(n == ERASE_LAT, "R5 erase latency", n, ERASE_LAT);
            model_erase(a);
        end
        @(negedge clk); #1;
        chk(err_status == stat_m, "R9 status", err_status, stat_m);
        chk(err_irq == (|stat_m), "R10 irq level", err_irq, |stat_m);
    endtask

    task automatic clear_all();
        err_clr_we = 1; err_clr_data = '1;
        @(negedge clk); err_clr_we = 0; err_clr_data = '0; #1;
        stat_m = '0;
        chk(err_status == 0, "R11 w1c clear", err_status, 0);
        chk(err_irq == 0, "R10 irq low", err_irq, 0);
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=finish");
        report();
        $finish;
    end

    initial begin
        int n, s, a;
        s = $urandom(32'h1357);
        for (int w = 0; w < WORDS; w++) mem_m[w] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk(ack == 0 && done == 0 && susp_ack == 0, "R1 outputs idle", {ack, done, susp_ack}, 0);
        chk(err_irq == 0 && err_status == 0, "R1 no error", err_status, 0);
        run_op(0, 0, 0, 0);                 // R1 erased word
        run_op(0, WORDS - 1, 0, 0);         // R1 erased word

        // Random mix of operations (R2 R4 R5 R9 R10 R11)
        for (int i = 0; i < 60; i++) begin
            int k;
            k = $urandom % 4;
            if (k == 3) k = 1;
            run_op(k, $urandom % WORDS, $urandom % 4, DATA_W'($urandom));
            if ($urandom % 4 == 0 && stat_m != 0) clear_all();
        end
        if (stat_m != 0) clear_all();

        // R3 back-to-back reads
        run_op(1, 5, 0, 16'h1234);
        run_op(1, 9, 1, 16'h0f0f);
        @(negedge clk);
        req_rd = 1; req_addr = 5; #1;
        chk(ack == 1, "R3 first ack", ack, 1);
        @(negedge clk); req_addr = 9; #1;
        chk(ack == 1 && done == 0, "R3 second ack before first done", {ack, done}, 2);
        @(negedge clk); req_rd = 0; #1;
        chk(done == 1 && rd_data == mem_m[5], "R3 first done", rd_data, mem_m[5]);
        @(negedge clk); #1;
        chk(done == 1 && rd_data == mem_m[9], "R3 second done", rd_data, mem_m[9]);

        // R6 request held while a program is busy
        issue(0, 1, 0, 12, 0, 16'h00ff);
        req_rd = 1; req_addr = 12;
        for (int k = 1; k <= PROG_LAT; k++) begin
            #1;
            chk(ack == 0, "R6 no ack while busy", ack, 0);
            if (k == PROG_LAT) chk(done == 1, "R6 done at latency", done, 1);
            @(negedge clk);
        end
        #1;
        chk(ack == 1, "R6 ack after done", ack, 1);
        mem_m[12] = mem_m[12] & 16'h00ff;
        @(negedge clk); req_rd = 0; #1;
        chk(done == 0, "R6 read not yet done", done, 0);
        @(negedge clk); #1;
        chk(done == 1 && rd_data == mem_m[12], "R4 program AND seen by read", rd_data, mem_m[12]);

        // R7 suspend mid-erase and just before its end
        for (int v = 0; v < 2; v++) begin
            int wk, r, expn;
            a = (v == 0) ? 17 : 22;
            wk = (v == 0) ? 5 : ERASE_LAT - 1;
            run_op(1, a, 0, 16'h0000);
            issue(0, 0, 1, a, 0, 0);
            repeat (wk - 1) @(negedge clk);
            susp_req = 1; #1;
            chk(susp_ack == 1, "R7 suspend ack", susp_ack, 1);
            r = ERASE_LAT - wk;
            expn = (r < SUSP_LAT) ? r : SUSP_LAT;
            @(negedge clk); susp_req = 0; #1;
            chk(susp_ack == 0, "R7 suspend ack is a pulse", susp_ack, 0);
            n = 1;
            while (!done && n < 400) begin @(negedge clk); #1; n++; end
            chk(n == expn, "R7 early done", n, expn);
            run_op(0, a, 0, 0);             // page kept: word still zero
        end

        // R8 suspend ignored when idle and during a program
        @(negedge clk); susp_req = 1; #1;
        chk(susp_ack == 0, "R8 idle suspend ignored", susp_ack, 0);
        issue(0, 1, 0, 3, 1, 16'hff00);
        n = 1; #1;
        while (!done && n < 400) begin
            chk(susp_ack == 0, "R8 no ack during program", susp_ack, 0);
            @(negedge clk); #1; n++;
        end
        susp_req = 0;
        chk(n == PROG_LAT, "R8 program timing unchanged", n, PROG_LAT);
        mem_m[3] = mem_m[3] & 16'hff00;
        run_op(0, 3, 0, 0);

        // R9 + R11: unsupported type, clear in the set cycle
        a = 20;
        issue(0, 1, 0, a, 2, 16'h0000);
        wait_done(n);
        chk(n == PROG_LAT, "R9 fault timing", n, PROG_LAT);
        err_clr_we = 1; err_clr_data = NB'(1 << bank_of(a));
        @(negedge clk); err_clr_we = 0; err_clr_data = '0; #1;
        stat_m[bank_of(a)] = 1'b1;
        chk(err_status == stat_m, "R11 set wins over clear", err_status, stat_m);
        chk(err_irq == 1, "R10 irq high", err_irq, 1);
        run_op(0, a, 0, 0);                 // R9 word unchanged
        clear_all();

        // R12 priority: program over erase, read over erase
        issue(0, 1, 1, 28, 0, 16'h5a5a);
        wait_done(n);
        chk(n == PROG_LAT, "R12 program beats erase", n, PROG_LAT);
        mem_m[28] = mem_m[28] & 16'h5a5a;
        issue(1, 0, 1, 28, 0, 0);
        wait_done(n);
        chk(n == 2 && rd_data == mem_m[28], "R12 read beats erase", rd_data, mem_m[28]);
        @(negedge clk); #1;
        chk(done == 0, "R12 loser not run", done, 0);

        // Final readback of the whole storage
        for (int w = 0; w < WORDS; w++) run_op(0, w, 0, 0);

        report();
        $finish;
    end
endmodule